// File: doc/BRIEF.md
# Search-Result Handshake Synchronizer

This block hands the outcome of a self-timed nearest-match search over to a clocked system. The search engine raises a search-end level when its winner flags and winner index have settled. The block brings that level into the system clock domain and waits a programmable number of cycles for the engine's output registers to resolve. It then loads the flags and index into its own registers on one clock edge and raises an acknowledge.

The acknowledge, together with a one-cycle search-begin-clear pulse, tells the engine to withdraw its search request. Search-end then falls, and the block drops the acknowledge in turn. That leaves it idle and ready for the next search.

The acknowledge behaves like a C-element. It rises only when a stored result and a high search-end agree. It falls only when search-end is low. A search-end pulse too short to cover the whole settle window is discarded rather than captured.

Top module: `srch_result_sync`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, the captured flags, the captured index, result_valid, ack and sb_clear are all zero.
- R2: While search_end is low, the captured outputs do not change and ack stays low, whatever the result inputs do.
- R3: With the default SETTLE_CYC of 3, the result inputs are loaded on the 6th rising edge after search_end rises: 2 synchronizer edges, 1 detect edge, then SETTLE_CYC settle edges. On the 5th edge nothing has been loaded yet.
- R4: If search_end falls before the settle window completes, no capture takes place, result_valid stays low and ack stays low.
- R5: result_valid is high for exactly the one cycle that follows the capture edge.
- R6: ack rises on the edge after the capture edge, never on the capture edge itself.
- R7: sb_clear is a single-cycle pulse that coincides with the first cycle of ack being high.
- R8: ack stays high for as long as search_end stays high. It falls on the 3rd rising edge after search_end falls.
- R9: Once captured, flags and index hold their values until the next capture, even if the result inputs change while ack is high.
- R10: Once ack has fallen, a new rise of search_end starts a fresh transfer with the same timing as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| search_end | input | 1 | Asynchronous search-finished level from the engine |
| win_flags_in | input | N_ROWS | Engine winner flags, one per stored row |
| win_idx_in | input | IDX_W | Engine winner index |
| win_flags_q | output | N_ROWS | Captured winner flags |
| win_idx_q | output | IDX_W | Captured winner index |
| result_valid | output | 1 | One-cycle strobe after a capture |
| ack | output | 1 | Transfer acknowledge, held until search_end falls |
| sb_clear | output | 1 | One-cycle request to clear the engine's search-begin |

## Verification
The bench counts edges precisely around the capture.

- A design that settles one cycle short would show result_valid on the 5th edge.
- A design that raises ack on the capture edge would expose the result to the engine before it was stored.
- A runt search_end, dropped after two edges, must produce no strobe. A design without the minimum-width check would capture stale data.

The bench also changes the result inputs while ack is high and while search_end is low. A design that keeps loading would pass the new values through. Finally, it runs transfers back to back and resets in the middle of an acknowledge. A design whose ack does not return cleanly would hang the second transfer or leave ack stuck after reset.

// File: rtl/srch_result_sync.sv
module srch_result_sync #(
  parameter int N_ROWS     = 8,
  parameter int IDX_W      = 3,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              search_end,
  input  logic [N_ROWS-1:0] win_flags_in,
  input  logic [IDX_W-1:0]  win_idx_in,
  output logic [N_ROWS-1:0] win_flags_q,
  output logic [IDX_W-1:0]  win_idx_q,
  output logic              result_valid,
  output logic              ack,
  output logic              sb_clear
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CAP, S_ACK} st_t;

  st_t             state;
  logic            se_meta, se_sync;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_meta <= 1'b0;
      se_sync <= 1'b0;
    end else begin
      se_meta <= search_end;
      se_sync <= se_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      win_flags_q <= '0;
      win_idx_q   <= '0;
      sb_clear    <= 1'b0;
    end else begin
      sb_clear <= (state == S_CAP);
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (se_sync) state <= S_SETTLE;
        end
        S_SETTLE: begin
          if (!se_sync) begin
            state <= S_IDLE;
          end else if (cnt == CNT_LAST) begin
            win_flags_q <= win_flags_in;
            win_idx_q   <= win_idx_in;
            state       <= S_CAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CAP:   state <= S_ACK;
        S_ACK:   if (!se_sync) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign result_valid = (state == S_CAP);
  assign ack          = (state == S_ACK);
endmodule

// File: rtl/srch_result_sync_chk.sv
module srch_result_sync_chk #(
  parameter int N_ROWS = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              search_end,
  input logic [N_ROWS-1:0] win_flags_q,
  input logic [IDX_W-1:0]  win_idx_q,
  input logic              result_valid,
  input logic              ack,
  input logic              sb_clear
);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_ack_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(result_valid));

  assert_sbclr_on_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_clear |-> (ack && !$past(ack)));

  assert_ack_fall_needs_low_se_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(search_end, 2));

  assert_capture_needs_se_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(search_end, 2));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(win_flags_q) && $stable(win_idx_q)));
endmodule

bind srch_result_sync srch_result_sync_chk #(.N_ROWS(N_ROWS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .search_end(search_end),
  .win_flags_q(win_flags_q), .win_idx_q(win_idx_q),
  .result_valid(result_valid), .ack(ack), .sb_clear(sb_clear)
);

// File: tb/srch_result_sync_test.sv
module srch_result_sync_test;
  localparam int N_ROWS = 8;
  localparam int IDX_W  = 3;
  localparam int NV     = 4;
  localparam logic [N_ROWS+IDX_W-1:0] VEC [0:NV-1] = '{
    11'b00000001_000, 11'b10000000_111, 11'b00100000_101, 11'b00010100_010};

  logic clk = 1'b0, rst_n = 1'b0, search_end = 1'b0;
  logic [N_ROWS-1:0] win_flags_in = '0, win_flags_q;
  logic [IDX_W-1:0]  win_idx_in = '0, win_idx_q;
  logic result_valid, ack, sb_clear;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srch_result_sync #(.N_ROWS(N_ROWS), .IDX_W(IDX_W), .SETTLE_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n), .search_end(search_end),
    .win_flags_in(win_flags_in), .win_idx_in(win_idx_in),
    .win_flags_q(win_flags_q), .win_idx_q(win_idx_q),
    .result_valid(result_valid), .ack(ack), .sb_clear(sb_clear));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [N_ROWS-1:0] f, input logic [IDX_W-1:0] x, input string tag);
    win_flags_in = f; win_idx_in = x; search_end = 1'b1;
    edges(5);
    check(result_valid == 0, {tag, " R3 no load on 5th edge"}, result_valid, 0);
    edges(1);
    check(result_valid == 1, {tag, " R5 valid after capture"}, result_valid, 1);
    check(win_flags_q == f, {tag, " R3 flags"}, win_flags_q, f);
    check(win_idx_q == x, {tag, " R3 idx"}, win_idx_q, x);
    check(ack == 0, {tag, " R6 no ack on capture edge"}, ack, 0);
    win_flags_in = ~f; win_idx_in = ~x;
    edges(1);
    check(result_valid == 0, {tag, " R5 single pulse"}, result_valid, 0);
    check(ack == 1, {tag, " R6 ack next edge"}, ack, 1);
    check(sb_clear == 1, {tag, " R7 sb_clear with ack rise"}, sb_clear, 1);
    edges(1);
    check(sb_clear == 0, {tag, " R7 sb_clear one cycle"}, sb_clear, 0);
    edges(4);
    check(ack == 1, {tag, " R8 ack held"}, ack, 1);
    check(win_flags_q == f && win_idx_q == x, {tag, " R9 result held"}, {win_flags_q, win_idx_q}, {f, x});
    search_end = 1'b0;
    edges(2);
    check(ack == 1, {tag, " R8 ack before 3rd edge"}, ack, 1);
    edges(1);
    check(ack == 0, {tag, " R8 ack falls 3rd edge"}, ack, 0);
  endtask

  initial begin
    #5;
    check(win_flags_q == 0 && win_idx_q == 0 && !result_valid && !ack && !sb_clear,
          "R1 reset state", {win_flags_q, win_idx_q}, 0);
    edges(2);
    rst_n = 1'b1;
    edges(1);
    check(!ack && !result_valid && win_flags_q == 0, "R1 after release", ack, 0);

    win_flags_in = 8'hFF; win_idx_in = 3'h7;
    edges(10);
    check(win_flags_q == 0 && win_idx_q == 0, "R2 idle ignores inputs", {win_flags_q, win_idx_q}, 0);
    check(ack == 0, "R2 ack low idle", ack, 0);

    for (int i = 0; i < NV; i++)
      xfer(VEC[i][N_ROWS+IDX_W-1:IDX_W], VEC[i][IDX_W-1:0], (i > 0) ? "R10 loop" : "loop");

    win_flags_in = 8'h3C; win_idx_in = 3'h4; search_end = 1'b1;
    edges(2);
    search_end = 1'b0;
    for (int k = 0; k < 8; k++) begin
      edges(1);
      check(!result_valid && !ack, "R4 runt no capture", {result_valid, ack}, 0);
    end
    check(win_flags_q == VEC[NV-1][N_ROWS+IDX_W-1:IDX_W], "R4 result unchanged", win_flags_q,
          VEC[NV-1][N_ROWS+IDX_W-1:IDX_W]);

    xfer(8'hC3, 3'h6, "R10 after runt");

    win_flags_in = 8'h11; win_idx_in = 3'h1; search_end = 1'b1;
    edges(8);
    check(ack == 1, "R8 ack before reset", ack, 1);
    rst_n = 1'b0;
    #1;
    check(!ack && win_flags_q == 0 && !sb_clear, "R1 mid-ack reset", {ack, win_flags_q}, 0);
    search_end = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(2);
    xfer(8'h80, 3'h3, "R10 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule